// File: doc/BRIEF.md
# Banked shadow register file

This block is the integer register file of a core that keeps several full copies (banks) of its 32 general-purpose registers. When an interrupt is taken, the core gives the handler a fresh bank instead of spilling live registers to memory. No data moves on a switch: only the bank selectors change. Two combinational read ports and one clocked write port serve ordinary three-operand instructions. Every port takes a 5-bit register number, and register 0 is a constant zero in every bank.

Two 3-bit selectors hold the current bank and the previous bank. An interrupt-entry pulse does two things: the current bank number moves into the previous selector, and a new current bank is taken from the interrupt vector number. A vector that names a bank that does not exist falls back to bank 0. A return pulse puts the previous bank back as the current one. A separate read/write port reaches the previous bank, so handler code can fetch or patch the state of the interrupted context.

The number of banks is a parameter from 1 to 8.

Top module: `shadow_gpr_file`

## Requirements
- R1: After reset, every register of every bank reads zero, and both `cur_set_o` and `prev_set_o` are 0.
- R2: Register 0 reads zero on all three read ports in every bank. Writes to register 0 through either write port have no effect.
- R3: `rs_a_data_o` and `rs_b_data_o` give, combinationally, the registers addressed by `rs_a_addr_i` and `rs_b_addr_i` in the current bank. A write is visible after the clock edge that takes it. A read of the same register in the cycle of the write returns the old value.
- R4: A write through the main port changes only the addressed register of the current bank. All other banks keep their contents.
- R5: When `irq_enter_i` is high at a clock edge, the following happens:
  - `prev_set_o` takes the old `cur_set_o`.
  - `cur_set_o` takes the vector number.
  - No register contents change.
  - With neither pulse high, both selectors hold their values.
- R6: When `irq_return_i` alone is high at a clock edge, `cur_set_o` takes `prev_set_o` and `prev_set_o` is unchanged. When both pulses are high, entry wins.
- R7: On entry, a vector number greater than or equal to NUM_BANKS selects bank 0.
- R8: `prev_rd_data_o` reads the bank named by `prev_set_o`, and `prev_wr_*` writes that bank. When both write ports target the same register of the same bank in one cycle, the main port's data is stored.
- R9: A write in the same cycle as a bank switch goes to the bank that was selected before the clock edge.
- R10: `cur_set_o` and `prev_set_o` are the plain binary bank index, 0 to NUM_BANKS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_a_addr_i | input | 5 | Read port A register number |
| rs_a_data_o | output | DATA_W | Read port A data, current bank |
| rs_b_addr_i | input | 5 | Read port B register number |
| rs_b_data_o | output | DATA_W | Read port B data, current bank |
| wr_en_i | input | 1 | Main write enable |
| wr_addr_i | input | 5 | Main write register number |
| wr_data_i | input | DATA_W | Main write data |
| irq_enter_i | input | 1 | Interrupt entry pulse |
| irq_vec_i | input | VEC_W | Vector number choosing the new bank |
| irq_return_i | input | 1 | Interrupt return pulse |
| prev_rd_addr_i | input | 5 | Previous-bank read register number |
| prev_rd_data_o | output | DATA_W | Previous-bank read data |
| prev_wr_en_i | input | 1 | Previous-bank write enable |
| prev_wr_addr_i | input | 5 | Previous-bank write register number |
| prev_wr_data_i | input | DATA_W | Previous-bank write data |
| cur_set_o | output | 3 | Current bank index |
| prev_set_o | output | 3 | Previous bank index |

## Verification
The bench builds the block with NUM_BANKS=4 and VEC_W=4. With these values, vectors 4 to 15 fall outside the bank range and exercise the fallback to bank 0, while 3 is the highest bank that is accepted. Four banks also leave room for the current and previous selectors to point at different banks, at the same bank, and past banks that have never been written. That makes bank isolation, no-copy entry, switch-cycle writes and the same-register collision between the two write ports all observable at the ports.

// File: rtl/shadow_gpr_pkg.sv
package shadow_gpr_pkg;
  localparam int unsigned MAX_BANKS  = 8;
  localparam int unsigned SET_W      = 3;
  localparam int unsigned REG_ADDR_W = 5;
  localparam int unsigned NUM_REGS   = 1 << REG_ADDR_W;

  typedef logic [SET_W-1:0]      set_t;
  typedef logic [REG_ADDR_W-1:0] reg_addr_t;

  typedef enum logic [1:0] {
    SW_HOLD   = 2'd0,
    SW_ENTER  = 2'd1,
    SW_RETURN = 2'd2
  } set_op_e;
endpackage

// File: rtl/gpr_set_ctrl.sv
module gpr_set_ctrl
  import shadow_gpr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned VEC_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             return_i,
  output set_t             cur_o,
  output set_t             prev_o
);
  set_op_e op;
  set_t    vec_set;
  set_t    cur_q, prev_q;

  always_comb begin
    if (enter_i)       op = SW_ENTER;  // entry beats return
    else if (return_i) op = SW_RETURN;
    else               op = SW_HOLD;
  end

  // out-of-range vector falls back to bank 0
  always_comb begin
    if (32'(vec_i) < NUM_BANKS) vec_set = set_t'(vec_i);
    else                        vec_set = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      case (op)
        SW_ENTER: begin
          prev_q <= cur_q;
          cur_q  <= vec_set;
        end
        SW_RETURN: cur_q <= prev_q;
        default: ;
      endcase
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import shadow_gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_we_i,
  input  reg_addr_t         pri_addr_i,
  input  logic [DATA_W-1:0] pri_data_i,
  input  logic              sec_we_i,
  input  reg_addr_t         sec_addr_i,
  input  logic [DATA_W-1:0] sec_data_i,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  // register 0 has no storage
  logic [DATA_W-1:0] store_q [NUM_REGS-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 1; r < NUM_REGS; r++) store_q[r] <= '0;
    end else begin
      for (int r = 1; r < NUM_REGS; r++) begin
        if (pri_we_i && pri_addr_i == reg_addr_t'(r))
          store_q[r] <= pri_data_i;
        else if (sec_we_i && sec_addr_i == reg_addr_t'(r))
          store_q[r] <= sec_data_i;
      end
    end
  end

  always_comb begin
    regs_o[0] = '0;
    for (int r = 1; r < NUM_REGS; r++) regs_o[r] = store_q[r];
  end
endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux
  import shadow_gpr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [DATA_W-1:0] regs_i [NUM_BANKS][NUM_REGS],
  input  set_t              set_i,
  input  reg_addr_t         addr_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (set_i == set_t'(b)) data_o = regs_i[b][addr_i];
    end
  end
endmodule

// File: rtl/shadow_gpr_file.sv
module shadow_gpr_file
  import shadow_gpr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned VEC_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        rs_a_addr_i,
  output logic [DATA_W-1:0] rs_a_data_o,
  input  logic [4:0]        rs_b_addr_i,
  output logic [DATA_W-1:0] rs_b_data_o,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_enter_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              irq_return_i,
  input  logic [4:0]        prev_rd_addr_i,
  output logic [DATA_W-1:0] prev_rd_data_o,
  input  logic              prev_wr_en_i,
  input  logic [4:0]        prev_wr_addr_i,
  input  logic [DATA_W-1:0] prev_wr_data_i,
  output logic [2:0]        cur_set_o,
  output logic [2:0]        prev_set_o
);
  set_t              cur_set, prev_set;
  logic [DATA_W-1:0] bank_regs [NUM_BANKS][NUM_REGS];

  gpr_set_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .VEC_W    (VEC_W)
  ) set_ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (irq_enter_i),
    .vec_i   (irq_vec_i),
    .return_i(irq_return_i),
    .cur_o   (cur_set),
    .prev_o  (prev_set)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic pri_we, sec_we;
    assign pri_we = wr_en_i      && (cur_set  == set_t'(b));
    assign sec_we = prev_wr_en_i && (prev_set == set_t'(b));

    gpr_bank #(.DATA_W(DATA_W)) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pri_we_i  (pri_we),
      .pri_addr_i(wr_addr_i),
      .pri_data_i(wr_data_i),
      .sec_we_i  (sec_we),
      .sec_addr_i(prev_wr_addr_i),
      .sec_data_i(prev_wr_data_i),
      .regs_o    (bank_regs[b])
    );
  end

  gpr_read_mux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) rd_a_i (
    .regs_i(bank_regs), .set_i(cur_set), .addr_i(rs_a_addr_i), .data_o(rs_a_data_o)
  );

  gpr_read_mux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) rd_b_i (
    .regs_i(bank_regs), .set_i(cur_set), .addr_i(rs_b_addr_i), .data_o(rs_b_data_o)
  );

  gpr_read_mux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) rd_prev_i (
    .regs_i(bank_regs), .set_i(prev_set), .addr_i(prev_rd_addr_i), .data_o(prev_rd_data_o)
  );

  assign cur_set_o  = cur_set;
  assign prev_set_o = prev_set;
endmodule

// File: rtl/shadow_gpr_file_chk.sv
module shadow_gpr_file_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        rs_a_addr_i,
  input logic [DATA_W-1:0] rs_a_data_o,
  input logic [4:0]        rs_b_addr_i,
  input logic [DATA_W-1:0] rs_b_data_o,
  input logic              wr_en_i,
  input logic [4:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_enter_i,
  input logic              irq_return_i,
  input logic [4:0]        prev_rd_addr_i,
  input logic [DATA_W-1:0] prev_rd_data_o,
  input logic [2:0]        cur_set_o,
  input logic [2:0]        prev_set_o
);
  AST_ZERO_READ_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_a_addr_i == 5'd0 |-> rs_a_data_o == '0); // R2
  AST_ZERO_READ_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_b_addr_i == 5'd0 |-> rs_b_data_o == '0); // R2
  AST_ZERO_READ_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_rd_addr_i == 5'd0 |-> prev_rd_data_o == '0); // R2
  AST_ENTER_SAVES_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_enter_i |=> prev_set_o == $past(cur_set_o)); // R5
  AST_SETS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_enter_i && !irq_return_i |=> $stable(cur_set_o) && $stable(prev_set_o)); // R5
  AST_RETURN_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_return_i && !irq_enter_i |=> cur_set_o == $past(prev_set_o) && $stable(prev_set_o)); // R6
  AST_CUR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cur_set_o) < NUM_BANKS); // R7
  AST_PREV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(prev_set_o) < NUM_BANKS); // R10
  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i != 5'd0 && !irq_enter_i && !irq_return_i
    |=> (rs_a_addr_i != $past(wr_addr_i)) || (rs_a_data_o == $past(wr_data_i))); // R3
endmodule

bind shadow_gpr_file shadow_gpr_file_chk #(
  .NUM_BANKS(NUM_BANKS),
  .DATA_W   (DATA_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rs_a_addr_i   (rs_a_addr_i),
  .rs_a_data_o   (rs_a_data_o),
  .rs_b_addr_i   (rs_b_addr_i),
  .rs_b_data_o   (rs_b_data_o),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .irq_enter_i   (irq_enter_i),
  .irq_return_i  (irq_return_i),
  .prev_rd_addr_i(prev_rd_addr_i),
  .prev_rd_data_o(prev_rd_data_o),
  .cur_set_o     (cur_set_o),
  .prev_set_o    (prev_set_o)
);

// File: tb/shadow_gpr_file_tb_top.sv
module shadow_gpr_file_tb_top;
  localparam int unsigned NB = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rs_a_addr = '0, rs_b_addr = '0, wr_addr = '0;
  logic [4:0]    prev_rd_addr = '0, prev_wr_addr = '0;
  logic [DW-1:0] rs_a_data, rs_b_data, prev_rd_data;
  logic [DW-1:0] wr_data = '0, prev_wr_data = '0;
  logic          wr_en = 1'b0, prev_wr_en = 1'b0;
  logic          irq_enter = 1'b0, irq_return = 1'b0;
  logic [VW-1:0] irq_vec = '0;
  logic [2:0]    cur_set, prev_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shadow_gpr_file #(.NUM_BANKS(NB), .DATA_W(DW), .VEC_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rs_a_addr_i(rs_a_addr), .rs_a_data_o(rs_a_data),
    .rs_b_addr_i(rs_b_addr), .rs_b_data_o(rs_b_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_enter_i(irq_enter), .irq_vec_i(irq_vec), .irq_return_i(irq_return),
    .prev_rd_addr_i(prev_rd_addr), .prev_rd_data_o(prev_rd_data),
    .prev_wr_en_i(prev_wr_en), .prev_wr_addr_i(prev_wr_addr), .prev_wr_data_i(prev_wr_data),
    .cur_set_o(cur_set), .prev_set_o(prev_set)
  );

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] a, output logic [DW-1:0] d);
    rs_a_addr = a; #1; d = rs_a_data;
  endtask

  task automatic rd_prev(input logic [4:0] a, output logic [DW-1:0] d);
    prev_rd_addr = a; #1; d = prev_rd_data;
  endtask

  task automatic enter(input logic [VW-1:0] v);
    irq_enter = 1'b1; irq_vec = v;
    step();
    irq_enter = 1'b0;
  endtask

  task automatic leave();
    irq_return = 1'b1;
    step();
    irq_return = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 cur_set after reset", DW'(cur_set), 0);
    chk("R1 prev_set after reset", DW'(prev_set), 0);
    rd_a(5'd1, d);  chk("R1 r1 zero", d, 0);
    rd_a(5'd31, d); chk("R1 r31 zero", d, 0);
    rd_prev(5'd17, d); chk("R1 prev r17 zero", d, 0);
  endtask

  task automatic t_read_write();
    logic [DW-1:0] d;
    wr(5'd5, 32'hA5A5_0005);
    wr(5'd31, 32'h3131_3131);
    rs_a_addr = 5'd5; rs_b_addr = 5'd31; #1;
    chk("R3 port A r5", rs_a_data, 32'hA5A5_0005);
    chk("R3 port B r31", rs_b_data, 32'h3131_3131);
    // same-cycle write and read: old value before the edge
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0000_C0DE; rs_a_addr = 5'd7; #1;
    chk("R3 same-cycle read old", rs_a_data, 0);
    step();
    wr_en = 1'b0;
    rd_a(5'd7, d); chk("R3 write visible next cycle", d, 32'h0000_C0DE);
  endtask

  task automatic t_zero();
    logic [DW-1:0] d;
    wr(5'd0, 32'hFFFF_FFFF);
    rs_a_addr = 5'd0; rs_b_addr = 5'd0; #1;
    chk("R2 port A r0", rs_a_data, 0);
    chk("R2 port B r0", rs_b_data, 0);
    prev_wr_en = 1'b1; prev_wr_addr = 5'd0; prev_wr_data = 32'hDEAD_BEEF;
    step();
    prev_wr_en = 1'b0;
    rd_prev(5'd0, d); chk("R2 prev port r0", d, 0);
  endtask

  task automatic t_enter_return();
    logic [DW-1:0] d;
    enter(4'd2);
    chk("R5 cur after enter", DW'(cur_set), 2);
    chk("R10 prev after enter", DW'(prev_set), 0);
    rd_a(5'd5, d); chk("R5 new bank not copied", d, 0);
    wr(5'd5, 32'h0000_BEEF);
    rd_a(5'd5, d); chk("R4 write in bank 2", d, 32'h0000_BEEF);
    rd_prev(5'd5, d); chk("R8 prev read bank 0", d, 32'hA5A5_0005);
    prev_wr_en = 1'b1; prev_wr_addr = 5'd31; prev_wr_data = 32'h0000_1111;
    step();
    prev_wr_en = 1'b0;
    leave();
    chk("R6 cur after return", DW'(cur_set), 0);
    chk("R6 prev kept", DW'(prev_set), 0);
    rd_a(5'd5, d);  chk("R4 bank 0 untouched", d, 32'hA5A5_0005);
    rd_a(5'd31, d); chk("R8 prev write landed", d, 32'h0000_1111);
  endtask

  task automatic t_clamp();
    enter(4'd9);
    chk("R7 vec 9 to bank 0", DW'(cur_set), 0);
    enter(4'd4);
    chk("R7 vec 4 to bank 0", DW'(cur_set), 0);
    enter(4'd3);
    chk("R7 vec 3 accepted", DW'(cur_set), 3);
    enter(4'd1);
    chk("R5 nested cur", DW'(cur_set), 1);
    chk("R5 nested prev", DW'(prev_set), 3);
    leave();
    chk("R6 return to 3", DW'(cur_set), 3);
  endtask

  task automatic t_priority();
    irq_enter = 1'b1; irq_vec = 4'd2; irq_return = 1'b1;
    step();
    irq_enter = 1'b0; irq_return = 1'b0;
    chk("R6 entry wins cur", DW'(cur_set), 2);
    chk("R6 entry wins prev", DW'(prev_set), 3);
    leave();
  endtask

  task automatic t_switch_write();
    logic [DW-1:0] d;
    wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h0000_9999;
    irq_enter = 1'b1; irq_vec = 4'd1;
    step();
    wr_en = 1'b0; irq_enter = 1'b0;
    rd_a(5'd9, d);    chk("R9 new bank untouched", d, 0);
    rd_prev(5'd9, d); chk("R9 write went to old bank", d, 32'h0000_9999);
  endtask

  task automatic t_collision();
    logic [DW-1:0] d;
    leave();
    chk("R6 cur equals prev", DW'(cur_set), 3);
    wr_en = 1'b1; wr_addr = 5'd10; wr_data = 32'h0000_AAAA;
    prev_wr_en = 1'b1; prev_wr_addr = 5'd10; prev_wr_data = 32'h0000_BBBB;
    step();
    wr_addr = 5'd11; wr_data = 32'h11;
    prev_wr_addr = 5'd12; prev_wr_data = 32'h12;
    step();
    wr_en = 1'b0; prev_wr_en = 1'b0;
    rd_a(5'd10, d); chk("R8 main port wins collision", d, 32'h0000_AAAA);
    rd_a(5'd11, d); chk("R8 main write lands", d, 32'h11);
    rd_a(5'd12, d); chk("R8 prev write lands", d, 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_write();
    t_zero();
    t_enter_return();
    t_clamp();
    t_priority();
    t_switch_write();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule